// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache Controller

This block is a small read-only cache placed between a processor load port and a slower backing memory. Lines are 16 bytes (four 32-bit words). They live in four sets of two ways each. Each way keeps its own tag, valid flag and line storage. A lookup compares both ways of the indexed set at once, and the word is returned from whichever way matched.

The processor side is a valid/ready request stream with an address. Replies come on a valid-only response stream, and a plain `cpu_wait` pin tells the processor that a miss is being serviced. On a miss the controller picks a victim way. An empty way is taken first; otherwise the set's least recently used way is taken. The line is then fetched one word per beat, starting with the requested word and wrapping around the line. The processor is released in the cycle the requested word comes back. The controller stays busy until the other three words are stored.

Back-pressure rules: a processor request transfers on a clock edge where both `cpu_req_valid` and `cpu_req_ready` are high. The response stream cannot be stalled, so the processor must take `cpu_rsp_data` in any cycle where `cpu_rsp_valid` is high. On the memory side, the controller holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. Memory replies arrive in request order and cannot be stalled.

Top module: `rd_cache2w`

## Requirements
- R1: A synchronous reset invalidates every line and clears every recency bit. Directly after reset, `cpu_req_ready` is high and `cpu_wait`, `cpu_rsp_valid` and `mem_req_valid` are low, and the first access to any line misses.
- R2: Address fields are: bits [3:2] select the word in the line, bits [5:4] select the set, and bits [31:6] form the tag. A way hits only if it is valid and its tag matches, and at most one way of a set hits.
- R3: A request is taken on a clock edge with `cpu_req_valid` and `cpu_req_ready` both high. `cpu_req_ready` is high only while the controller is idle, so a request presented while busy is neither taken nor answered.
- R4: On a hit, `cpu_rsp_valid` is high with the word's data in the cycle right after the request is taken. `cpu_wait` stays low and no memory request is made.
- R5: On a miss, `cpu_wait` is high in the cycle after the request is taken. It stays high until the requested word arrives, and it is never high together with `cpu_rsp_valid`.
- R6: A refill issues exactly four word requests for the missing line. They go in wrapping order starting at the requested word (w, w+1, w+2, w+3, each modulo 4), each as a byte address with the line's tag and set and bits [1:0] zero.
- R7: In the cycle the first refill word arrives, `cpu_rsp_valid` is high with that word and `cpu_wait` is low. `cpu_req_ready` stays low until the fourth word has been stored.
- R8: The victim on a miss is an invalid way if the set has one (way 0 before way 1). Otherwise it is the way named by the set's recency bit.
- R9: A set's recency bit is updated on every hit and every completed fill so that it names the way not most recently used.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle still has `mem_req_valid` high with the same `mem_req_addr`.
- R11: After a refill, all four words of the line hit and return the data the memory supplied for their addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor read request present |
| cpu_req_ready | output | 1 | Controller idle and able to take a request |
| cpu_req_addr | input | 32 | Byte address of the requested word |
| cpu_wait | output | 1 | Miss in progress, requested word not yet delivered |
| cpu_rsp_valid | output | 1 | Read data valid this cycle |
| cpu_rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Backing-memory word request present |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Returned word present |
| mem_rsp_data | input | 32 | Returned word |

## Verification
The assertions assume that backing memory returns exactly one word per accepted request, in order, and never returns data when no refill is outstanding. The bench's memory model replies a fixed two cycles after each accepted request and can throttle `mem_req_ready` in a repeating pattern. Reset is only applied while the controller is idle. Processor requests wait for `cpu_req_ready`, except for one deliberate poke during each refill, which must be ignored.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } rc_phase_e;
endpackage

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] look_set,
  input  logic [TAG_W-1:0] look_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec,
  input  logic             alloc_en,
  input  logic [WAY_W-1:0] alloc_way,
  input  logic [SET_W-1:0] alloc_set,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             commit_en,
  input  logic [WAY_W-1:0] commit_way,
  input  logic [SET_W-1:0] commit_set
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
      end else begin
        if (alloc_en && alloc_way == WAY_W'(w))
          vld_q[alloc_set] <= 1'b0;
        if (commit_en && commit_way == WAY_W'(w))
          vld_q[commit_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && alloc_way == WAY_W'(w))
        tag_q[alloc_set] <= alloc_tag;
    end

    assign valid_vec[w] = vld_q[look_set];
    assign hit_vec[w]   = vld_q[look_set] && (tag_q[look_set] == look_tag);
  end
endmodule

// File: rtl/rc_line_store.sv
module rc_line_store #(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int SET_W      = 2,
  parameter int WORD_W     = 2,
  parameter int WAY_W      = 1
) (
  input  logic                         clk,
  input  logic [SET_W-1:0]             rd_set,
  input  logic [WORD_W-1:0]            rd_word,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  input  logic                         wr_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [SET_W-1:0]             wr_set,
  input  logic [WORD_W-1:0]            wr_word,
  input  logic [DATA_W-1:0]            wr_data
);
  localparam int ENTRIES = SETS * LINE_WORDS;
  localparam int IDX_W   = SET_W + WORD_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] word_q [ENTRIES];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w))
        word_q[IDX_W'({wr_set, wr_word})] <= wr_data;
    end

    assign rd_data[w] = word_q[IDX_W'({rd_set, rd_word})];
  end
endmodule

// File: rtl/rc_recency.sv
module rc_recency #(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] look_set,
  input  logic [1:0]       valid_vec,
  output logic             victim_way,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way
);
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst)
      older_q <= '0;
    else if (touch_en)
      older_q[touch_set] <= ~touch_way;
  end

  always_comb begin
    if (!valid_vec[0])
      victim_way = 1'b0;
    else if (!valid_vec[1])
      victim_way = 1'b1;
    else
      victim_way = older_q[look_set];
  end
endmodule

// File: rtl/rc_refill_ctl.sv
module rc_refill_ctl
  import rc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 26,
  parameter int SET_W      = 2,
  parameter int WORD_W     = 2,
  parameter int BYTE_OFS   = 2,
  parameter int WAY_W      = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req_valid,
  input  logic [ADDR_W-1:BYTE_OFS] cpu_req_word_addr,
  output logic                     cpu_req_ready,
  output logic                     cpu_wait,
  output logic                     cpu_rsp_valid,
  output logic                     rsp_from_mem,
  output logic                     ph_lookup,
  output logic                     ph_fill,
  output logic [SET_W-1:0]         look_set,
  output logic [TAG_W-1:0]         look_tag,
  output logic [WORD_W-1:0]        look_word,
  input  logic                     hit_any,
  input  logic [WAY_W-1:0]         hit_way,
  input  logic [WAY_W-1:0]         victim_way,
  output logic                     alloc_en,
  output logic [WAY_W-1:0]         alloc_way,
  output logic                     commit_en,
  output logic [WAY_W-1:0]         fill_way,
  output logic                     touch_en,
  output logic [WAY_W-1:0]         touch_way,
  output logic                     wr_en,
  output logic [WORD_W-1:0]        wr_word,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid
);
  localparam int CNT_W = $clog2(LINE_WORDS + 1);
  localparam int LAST  = LINE_WORDS - 1;

  rc_phase_e                 st_q;
  logic [ADDR_W-1:BYTE_OFS]  addr_q;
  logic [WAY_W-1:0]          victim_q;
  logic [CNT_W-1:0]          issue_q;
  logic [CNT_W-1:0]          recv_q;
  logic                      crit_done_q;
  logic                      last_beat;
  logic [WORD_W-1:0]         issue_word;

  assign look_word = addr_q[BYTE_OFS +: WORD_W];
  assign look_set  = addr_q[BYTE_OFS + WORD_W +: SET_W];
  assign look_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign last_beat  = (recv_q == CNT_W'(LAST));
  assign issue_word = look_word + issue_q[WORD_W-1:0];
  assign wr_word    = look_word + recv_q[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      issue_q     <= '0;
      recv_q      <= '0;
      crit_done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            addr_q <= cpu_req_word_addr;
            st_q   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit_any) begin
            st_q <= ST_IDLE;
          end else begin
            st_q        <= ST_FILL;
            victim_q    <= victim_way;
            issue_q     <= '0;
            recv_q      <= '0;
            crit_done_q <= 1'b0;
          end
        end
        ST_FILL: begin
          if (mem_req_valid && mem_req_ready)
            issue_q <= issue_q + 1'b1;
          if (mem_rsp_valid) begin
            recv_q      <= recv_q + 1'b1;
            crit_done_q <= 1'b1;
            if (last_beat)
              st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ph_lookup     = (st_q == ST_LOOKUP);
    ph_fill       = (st_q == ST_FILL);
    cpu_req_ready = (st_q == ST_IDLE);
    alloc_en      = ph_lookup && !hit_any;
    alloc_way     = victim_way;
    cpu_wait      = alloc_en || (ph_fill && !crit_done_q && !mem_rsp_valid);
    cpu_rsp_valid = (ph_lookup && hit_any) ||
                    (ph_fill && mem_rsp_valid && !crit_done_q);
    rsp_from_mem  = ph_fill;
    wr_en         = ph_fill && mem_rsp_valid;
    commit_en     = wr_en && last_beat;
    fill_way      = victim_q;
    touch_en      = (ph_lookup && hit_any) || commit_en;
    touch_way     = ph_lookup ? hit_way : victim_q;
    mem_req_valid = ph_fill && (issue_q < CNT_W'(LINE_WORDS));
    mem_req_addr  = {look_tag, look_set, issue_word, {BYTE_OFS{1'b0}}};
  end
endmodule

// File: rtl/rd_cache2w.sv
module rd_cache2w #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_wait,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int WAYS     = 2;
  localparam int WAY_W    = 1;
  localparam int BYTE_OFS = $clog2(DATA_W / 8);
  localparam int WORD_W   = $clog2(LINE_WORDS);
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - SET_W - WORD_W - BYTE_OFS;

  logic [SET_W-1:0]            look_set;
  logic [TAG_W-1:0]            look_tag;
  logic [WORD_W-1:0]           look_word;
  logic [WAYS-1:0]             hit_vec;
  logic [WAYS-1:0]             valid_vec;
  logic                        hit_any;
  logic [WAY_W-1:0]            hit_way;
  logic [WAY_W-1:0]            victim_way;
  logic                        alloc_en;
  logic [WAY_W-1:0]            alloc_way;
  logic                        commit_en;
  logic [WAY_W-1:0]            fill_way;
  logic                        touch_en;
  logic [WAY_W-1:0]            touch_way;
  logic                        wr_en;
  logic [WORD_W-1:0]           wr_word;
  logic                        rsp_from_mem;
  logic                        ph_lookup;
  logic                        ph_fill;
  logic [WAYS-1:0][DATA_W-1:0] way_words;
  logic                        unused_byte_bits;

  assign unused_byte_bits = ^cpu_req_addr[BYTE_OFS-1:0];
  assign hit_any          = |hit_vec;
  assign hit_way          = hit_vec[1];
  assign cpu_rsp_data     = rsp_from_mem ? mem_rsp_data : way_words[hit_way];

  rc_refill_ctl #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .SET_W(SET_W),
    .WORD_W(WORD_W), .BYTE_OFS(BYTE_OFS), .WAY_W(WAY_W)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid),
    .cpu_req_word_addr(cpu_req_addr[ADDR_W-1:BYTE_OFS]),
    .cpu_req_ready(cpu_req_ready), .cpu_wait(cpu_wait),
    .cpu_rsp_valid(cpu_rsp_valid), .rsp_from_mem(rsp_from_mem),
    .ph_lookup(ph_lookup), .ph_fill(ph_fill),
    .look_set(look_set), .look_tag(look_tag), .look_word(look_word),
    .hit_any(hit_any), .hit_way(hit_way), .victim_way(victim_way),
    .alloc_en(alloc_en), .alloc_way(alloc_way),
    .commit_en(commit_en), .fill_way(fill_way),
    .touch_en(touch_en), .touch_way(touch_way),
    .wr_en(wr_en), .wr_word(wr_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
  );

  rc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst(rst),
    .look_set(look_set), .look_tag(look_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .alloc_en(alloc_en), .alloc_way(alloc_way),
    .alloc_set(look_set), .alloc_tag(look_tag),
    .commit_en(commit_en), .commit_way(fill_way), .commit_set(look_set)
  );

  rc_line_store #(
    .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
    .SET_W(SET_W), .WORD_W(WORD_W), .WAY_W(WAY_W)
  ) u_lines (
    .clk(clk),
    .rd_set(look_set), .rd_word(look_word), .rd_data(way_words),
    .wr_en(wr_en), .wr_way(fill_way), .wr_set(look_set),
    .wr_word(wr_word), .wr_data(mem_rsp_data)
  );

  rc_recency #(
    .SETS(SETS), .SET_W(SET_W)
  ) u_lru (
    .clk(clk), .rst(rst),
    .look_set(look_set), .valid_vec(valid_vec), .victim_way(victim_way),
    .touch_en(touch_en), .touch_set(look_set), .touch_way(touch_way)
  );
endmodule

// File: rtl/rc_cache_checker.sv
module rc_cache_checker #(
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFS = 2,
  parameter int WORD_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_wait,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        hit_vec,
  input logic              ph_lookup,
  input logic              ph_fill
);
  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    ph_lookup |-> $onehot0(hit_vec));

  assert_take_then_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> (ph_lookup && !cpu_req_ready));

  assert_hit_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (ph_lookup && (|hit_vec)) |-> (cpu_rsp_valid && !cpu_wait && !mem_req_valid));

  assert_wait_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wait && cpu_rsp_valid));

  assert_wrap_order_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=>
      (!mem_req_valid ||
       (mem_req_addr[BYTE_OFS +: WORD_W] ==
        WORD_W'($past(mem_req_addr[BYTE_OFS +: WORD_W]) + 1'b1))));

  assert_busy_in_fill_R7: assert property (@(posedge clk) disable iff (rst)
    ph_fill |-> !cpu_req_ready);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind rd_cache2w rc_cache_checker #(
  .ADDR_W(ADDR_W), .BYTE_OFS(BYTE_OFS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_wait(cpu_wait), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .hit_vec(hit_vec),
  .ph_lookup(ph_lookup), .ph_fill(ph_fill)
);

// File: tb/rd_cache2w_tb_top.sv
`timescale 1ns/1ps
module rd_cache2w_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [31:0] cpu_req_addr = '0;
  logic        cpu_wait;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int beats_back = 0;
  bit bp_en = 1'b0;
  logic [31:0] pend_a[$];
  int          pend_t[$];
  logic [31:0] req_log[$];
  logic [31:0] exp_q[$];
  bit          hold_pending = 1'b0;
  logic [31:0] hold_addr = '0;

  always #2.5 clk = ~clk;

  rd_cache2w dut_i (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_wait(cpu_wait),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] adr(int t, int s, int w);
    return {26'(t), 2'(s), 2'(w), 2'b00};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Backing-memory model: fixed two-cycle reply, optional ready throttling.
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend_a.size() > 0 && pend_t[0] <= cyc) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_word(pend_a[0]);
      void'(pend_a.pop_front());
      void'(pend_t.pop_front());
      beats_back++;
    end
    if (!rst && mem_req_valid && mem_req_ready) begin
      pend_a.push_back(mem_req_addr);
      pend_t.push_back(cyc + 2);
      req_log.push_back(mem_req_addr);
    end
    mem_req_ready <= bp_en ? ((cyc % 3) != 1) : 1'b1;
    cyc++;
  end

  // Scoreboard monitor: every response pops one expected word (R11 data).
  always @(negedge clk) begin
    if (!rst && cpu_rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "response with no accepted request", cpu_rsp_data, 32'h0);
      end else begin
        chk(cpu_rsp_data == exp_q[0], "R11", "read data", cpu_rsp_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // R10: a stalled memory request keeps its address.
  always @(negedge clk) begin
    if (!rst && hold_pending)
      chk(mem_req_valid && mem_req_addr == hold_addr, "R10", "held memory request",
          mem_req_addr, hold_addr);
    hold_pending = !rst && mem_req_valid && !mem_req_ready;
    hold_addr    = mem_req_addr;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs straight after reset
    chk(cpu_req_ready, "R1", "ready after reset", 32'(cpu_req_ready), 32'h1);
    chk(!cpu_wait && !cpu_rsp_valid, "R1", "wait/rsp after reset",
        {30'h0, cpu_wait, cpu_rsp_valid}, 32'h0);
    chk(!mem_req_valid, "R1", "memory idle after reset", 32'(mem_req_valid), 32'h0);
  endtask

  task automatic access(logic [31:0] a, bit exp_hit);
    int base_req;
    int base_beats;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    while (!cpu_req_ready) @(negedge clk);
    exp_q.push_back(mem_word({a[31:2], 2'b00}));
    base_req   = req_log.size();
    base_beats = beats_back;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (exp_hit) begin
      // R4: reply one cycle after acceptance, no wait
      chk(cpu_rsp_valid && !cpu_wait, "R4", "hit reply timing",
          {30'h0, cpu_rsp_valid, cpu_wait}, 32'h2);
      @(negedge clk);
      chk(req_log.size() == base_req && cpu_req_ready, "R4", "hit made memory traffic",
          32'(req_log.size() - base_req), 32'h0);
    end else begin
      // R5: wait raised on a miss
      chk(cpu_wait && !cpu_rsp_valid, "R5", "miss wait",
          {30'h0, cpu_rsp_valid, cpu_wait}, 32'h1);
      while (!cpu_rsp_valid) @(negedge clk);
      // R7: released on the first beat, still busy
      chk(!cpu_req_ready && !cpu_wait && beats_back == base_beats + 1, "R7",
          "early release", 32'(beats_back - base_beats), 32'h1);
      // R3: a request poked while busy must be ignored
      cpu_req_valid = 1'b1;
      cpu_req_addr  = a ^ 32'h0000_1000;
      while (!cpu_req_ready) @(negedge clk);
      cpu_req_valid = 1'b0;
      chk(beats_back == base_beats + 4, "R7", "ready only after fourth beat",
          32'(beats_back - base_beats), 32'h4);
      chk(req_log.size() == base_req + 4, "R6", "refill request count",
          32'(req_log.size() - base_req), 32'h4);
      for (int i = 0; i < 4; i++) begin
        logic [31:0] want;
        want = {a[31:4], 2'(a[3:2] + 2'(i)), 2'b00};
        if (req_log.size() > base_req + i)
          chk(req_log[base_req + i] == want, "R6", "wrap order", req_log[base_req + i], want);
      end
    end
  endtask

  initial begin
    do_reset();                                // R1
    access(adr(1, 0, 2), 1'b0);                // R1 first access misses; R6 order 2,3,0,1
    for (int w = 0; w < 4; w++) access(adr(1, 0, w), 1'b1);  // R11 whole line resident
    access(adr(2, 0, 0), 1'b0);                // R8 fills the invalid way
    access(adr(1, 0, 1), 1'b1);                // R8 first line kept
    access(adr(2, 0, 3), 1'b1);                // R2 both ways hit independently
    access(adr(1, 0, 0), 1'b1);                // R9 tag 2 now older
    access(adr(3, 0, 1), 1'b0);                // R8 replaces tag 2
    access(adr(1, 0, 3), 1'b1);                // R9 tag 1 survived
    access(adr(2, 0, 2), 1'b0);                // R9 tag 2 was evicted, replaces tag 3
    access(adr(1, 0, 2), 1'b1);
    access(adr(2, 0, 1), 1'b1);                // R9 tag 2 resident, tag 1 now older
    access(adr(3, 0, 0), 1'b0);                // R9 replaces tag 1
    access(adr(2, 0, 0), 1'b1);
    access(adr(1, 0, 0), 1'b0);                // R9 tag 1 gone
    bp_en = 1'b1;                              // R10 throttled memory
    access(adr(4, 2, 3), 1'b0);
    access(adr(4, 2, 0), 1'b1);
    access(adr(5, 3, 1), 1'b0);
    bp_en = 1'b0;
    for (int s = 1; s < 4; s++) begin
      access(adr(7, s, s), 1'b0);
      access(adr(7, s, (s + 2) % 4), 1'b1);
    end
    access(adr(4, 2, 1), 1'b1);                // R8 invalid way was used, tag 4 kept
    do_reset();
    access(adr(1, 0, 0), 1'b0);                // R1 reset cleared a resident line
    access(adr(7, 1, 1), 1'b0);                // R1
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "responses outstanding", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule